// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts activity inside a processor core. It has three 32-bit counters. One counts clock cycles. The other two each count whichever event the software selects. The core supplies a vector of one-cycle event pulses, indexed by event code, and one external trace-output signal. Software reaches the unit through a small synchronous register port that exposes four words: a control/status word and the three counter values.

There is no per-counter enable. A single global enable starts and stops every counter. Two clear bits reset counters in groups: one clears both event counters, the other clears the cycle counter. When a counter wraps, it sets a sticky overflow flag. Writing a one to a flag clears it. One interrupt line is raised whenever any flagged counter also has its interrupt enable set. Software can park an event counter by pointing it at the trace-output code while that input is held low.

Top module: `evt_pmu`

## Requirements
- R1: After reset, all three counters read 0, the control word reads 0 and `irq` is low.
- R2: Address 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. `bus_rdata` shows the addressed word in the same cycle. A write to a counter address loads `bus_wdata` into it at the next edge; zero is allowed.
- R3: Control word fields are: bit 0 global enable, bit 3 cycle prescaler enable, bits 4/5/6 interrupt enables (event 0, event 1, cycle), bits 8/9/10 overflow flags (same order), bits 27:20 event-0 code, bits 19:12 event-1 code. All other bits read 0.
- R4: An event counter adds one in each cycle where the global enable is set and `ev_pulse[code]` is high. A code of `NUM_EV` or more (other than 0x20) never counts.
- R5: Event code 0x20 counts cycles in which `trace_in` is high. While `trace_in` is low, the counter holds.
- R6: While the global enable is 0, no counter changes except by a direct write or a clear bit.
- R7: With the global enable set, the cycle counter adds one every cycle. With the prescaler bit also set, it adds one once every 64 enabled cycles.
- R8: Writing control bit 1 as one clears both event counters. Writing bit 2 as one clears the cycle counter and restarts the prescaler phase. Both bits always read 0.
- R9: When a counter steps from 0xFFFFFFFF, it becomes 0 and its overflow flag is set at the same edge. The flag stays set until cleared.
- R10: A control write clears each flag whose bit in `bus_wdata` is one and leaves flags written as zero untouched. A wrap in the same cycle keeps its flag set.
- R11: `irq` is high exactly when some counter has both its overflow flag and its interrupt enable set.
- R12: Priority on each counter is a direct write first, then a clear bit, then an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_pulse | input | NUM_EV | One-cycle event pulses indexed by event code |
| trace_in | input | 1 | External trace-output level, counted by code 0x20 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Every counter and every control field is visible on `bus_rdata`, and `irq` is observed on every cycle. A wrong increment, missed clear or stuck flag therefore shows up as a mismatch in the first cycle the bench reads that address. The bench rotates the read address during idle traffic, so internal drift is seen within four cycles. A wrong prescaler phase or a bad wrap shows up as a wrong cycle count or a wrong flag or `irq` value on the edge that should have changed it.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int CODE_W = 8;
  localparam int NCTR = 3;           // index 0: event 0, 1: event 1, 2: cycles
  localparam logic [CODE_W-1:0] TRACE_CODE = 8'h20;

  typedef enum logic [AW-1:0] {
    REG_CTRL = 2'd0,
    REG_CYC  = 2'd1,
    REG_EV0  = 2'd2,
    REG_EV1  = 2'd3
  } reg_sel_e;

  // control word bit positions (decoded by software)
  localparam int B_EN     = 0;
  localparam int B_CLR_EV = 1;
  localparam int B_CLR_CY = 2;
  localparam int B_PSC    = 3;
  localparam int B_IEN    = 4;
  localparam int B_OVF    = 8;
  localparam int B_SEL1   = 12;
  localparam int B_SEL0   = 20;
endpackage

// File: rtl/pmu_evsel.sv
module pmu_evsel #(
  parameter int NUM_EV = 32,
  parameter int CW = 8,
  parameter logic [CW-1:0] TRACE = 8'h20
) (
  input  logic [NUM_EV-1:0] ev,
  input  logic              trace,
  input  logic [CW-1:0]     code,
  output logic              hit
);
  logic hit_ev;

  always_comb begin
    hit_ev = 1'b0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (code == CW'(i)) hit_ev = ev[i];
    end
  end

  assign hit = (code == TRACE) ? trace : hit_ev;
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic div_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr)      ph_d = '0;
    else if (run) ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign tick = run && (!div_en || ph_q == LAST);

  AST_PSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_en && !clr) |=> (!tick || !div_en)); // R7
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         step;

  assign step = inc && !ld && !clr;
  assign wrap = step && (&cnt);

  always_comb begin
    cnt_d = cnt;
    if (ld)        cnt_d = ld_val;
    else if (clr)  cnt_d = '0;
    else if (step) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val)); // R12
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> cnt == '0); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R9
endmodule

// File: rtl/evt_pmu.sv
module evt_pmu
  import pmu_pkg::*;
#(
  parameter int NUM_EV = 32,
  parameter int PSC_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic              trace_in,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // control state
  logic              en_q, en_d, psc_q, psc_d;
  logic [NCTR-1:0]   ien_q, ien_d, ovf_q, ovf_d;
  logic [CODE_W-1:0] sel_q [2];
  logic [CODE_W-1:0] sel_d [2];

  logic ctrl_wr, clr_ev, clr_cy, cyc_tick;
  logic [NCTR-1:0] ld, clr, inc, wrap;
  logic [DW-1:0]   cnt [NCTR];
  logic [1:0]      hit;

  assign ctrl_wr = bus_we && (bus_addr == REG_CTRL);
  assign clr_ev  = ctrl_wr && bus_wdata[B_CLR_EV];
  assign clr_cy  = ctrl_wr && bus_wdata[B_CLR_CY];

  assign ld[0]  = bus_we && (bus_addr == REG_EV0);
  assign ld[1]  = bus_we && (bus_addr == REG_EV1);
  assign ld[2]  = bus_we && (bus_addr == REG_CYC);
  assign clr    = {clr_cy, clr_ev, clr_ev};
  assign inc    = {cyc_tick, en_q && hit[1], en_q && hit[0]};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_sel
      pmu_evsel #(.NUM_EV(NUM_EV), .CW(CODE_W), .TRACE(TRACE_CODE)) u_sel (
        .ev(ev_pulse), .trace(trace_in), .code(sel_q[g]), .hit(hit[g]));
    end
    for (g = 0; g < NCTR; g++) begin : g_ctr
      pmu_counter #(.W(DW)) u_ctr (
        .clk(clk), .rst_n(rst_ni), .ld(ld[g]), .ld_val(bus_wdata),
        .clr(clr[g]), .inc(inc[g]), .cnt(cnt[g]), .wrap(wrap[g]));
    end
  endgenerate

  pmu_prescaler #(.DIV(PSC_DIV)) u_psc (
    .clk(clk), .rst_n(rst_ni), .run(en_q), .clr(clr_cy),
    .div_en(psc_q), .tick(cyc_tick));

  // next state of the control word
  always_comb begin
    en_d     = en_q;
    psc_d    = psc_q;
    ien_d    = ien_q;
    sel_d[0] = sel_q[0];
    sel_d[1] = sel_q[1];
    ovf_d    = ovf_q;
    if (ctrl_wr) begin
      en_d     = bus_wdata[B_EN];
      psc_d    = bus_wdata[B_PSC];
      ien_d    = bus_wdata[B_IEN +: NCTR];
      sel_d[0] = bus_wdata[B_SEL0 +: CODE_W];
      sel_d[1] = bus_wdata[B_SEL1 +: CODE_W];
      ovf_d    = ovf_q & ~bus_wdata[B_OVF +: NCTR];
    end
    ovf_d = ovf_d | wrap;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      psc_q    <= 1'b0;
      ien_q    <= '0;
      ovf_q    <= '0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
    end else begin
      en_q     <= en_d;
      psc_q    <= psc_d;
      ien_q    <= ien_d;
      ovf_q    <= ovf_d;
      sel_q[0] <= sel_d[0];
      sel_q[1] <= sel_d[1];
    end
  end

  // read path
  always_comb begin
    case (bus_addr)
      REG_CYC: bus_rdata = cnt[2];
      REG_EV0: bus_rdata = cnt[0];
      REG_EV1: bus_rdata = cnt[1];
      default: bus_rdata = {4'b0, sel_q[0], sel_q[1], 1'b0, ovf_q,
                            1'b0, ien_q, psc_q, 2'b00, en_q};
    endcase
  end

  assign irq = |(ovf_q & ien_q);

  generate
    for (g = 0; g < NCTR; g++) begin : g_chk
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
        (ovf_q[g] && !(ctrl_wr && bus_wdata[B_OVF + g])) |=> ovf_q[g]); // R9
      AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
        (ctrl_wr && bus_wdata[B_OVF + g] && !wrap[g]) |=> !ovf_q[g]); // R10
      AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
        wrap[g] |=> ovf_q[g]); // R9
    end
  endgenerate

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_q && !bus_we) |=> ($stable(cnt[0]) && $stable(cnt[1]) && $stable(cnt[2]))); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq); // R11
endmodule

// File: tb/evt_pmu_test.sv
module evt_pmu_test;
  localparam int NEV = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NEV-1:0]  ev_pulse;
  logic            trace_in;
  logic            bus_we;
  logic [1:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq;

  evt_pmu #(.NUM_EV(NEV), .PSC_DIV(64)) uut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .trace_in(trace_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;   // 250 MHz

  int    n_chk = 0, n_bad = 0;
  int    cycles = 0;
  bit    done = 0;
  string req = "R1";

  // behavioural reference state
  bit        m_en, m_psc;
  bit [2:0]  m_ien, m_ovf;
  bit [7:0]  m_sel0, m_sel1;
  bit [31:0] m_c0, m_c1, m_cy;
  int        m_pre;

  function automatic bit m_hit(bit [7:0] code, bit [NEV-1:0] ev, bit tr);
    if (code == 8'h20) return tr;
    if (code < NEV)    return ev[code];
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_ctrl();
    return {4'b0, m_sel0, m_sel1, 1'b0, m_ovf, 1'b0, m_ien, m_psc, 2'b0, m_en};
  endfunction

  function automatic bit [31:0] m_read(bit [1:0] a);
    case (a)
      2'd0: return m_ctrl();
      2'd1: return m_cy;
      2'd2: return m_c0;
      default: return m_c1;
    endcase
  endfunction

  task automatic check(string r, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", r, act, exp, cycles);
    end
  endtask

  task automatic m_step(bit we, bit [1:0] a, bit [31:0] wd, bit [NEV-1:0] ev, bit tr);
    bit i0, i1, ic, cw, w0, w1, wc;
    i0 = m_en && m_hit(m_sel0, ev, tr);
    i1 = m_en && m_hit(m_sel1, ev, tr);
    ic = m_en && (!m_psc || m_pre == 63);
    cw = we && a == 2'd0;
    w0 = 0; w1 = 0; wc = 0;
    if (we && a == 2'd2) m_c0 = wd;
    else if (cw && wd[1]) m_c0 = 0;
    else if (i0) begin w0 = (m_c0 == 32'hFFFF_FFFF); m_c0 = m_c0 + 1; end
    if (we && a == 2'd3) m_c1 = wd;
    else if (cw && wd[1]) m_c1 = 0;
    else if (i1) begin w1 = (m_c1 == 32'hFFFF_FFFF); m_c1 = m_c1 + 1; end
    if (we && a == 2'd1) m_cy = wd;
    else if (cw && wd[2]) m_cy = 0;
    else if (ic) begin wc = (m_cy == 32'hFFFF_FFFF); m_cy = m_cy + 1; end
    if (cw && wd[2]) m_pre = 0;
    else if (m_en) m_pre = (m_pre + 1) % 64;
    if (cw) begin
      m_en = wd[0]; m_psc = wd[3]; m_ien = wd[6:4];
      m_sel0 = wd[27:20]; m_sel1 = wd[19:12];
      m_ovf = m_ovf & ~wd[10:8];
    end
    m_ovf = m_ovf | {wc, w1, w0};
  endtask

  // one clock: drive at negedge, compare, then advance the model
  task automatic cyc(bit we, bit [1:0] a, bit [31:0] wd, bit [NEV-1:0] ev, bit tr);
    bus_we = we; bus_addr = a; bus_wdata = wd; ev_pulse = ev; trace_in = tr;
    #1;
    check(req, bus_rdata, m_read(a));
    check("R11", {31'b0, irq}, {31'b0, |(m_ovf & m_ien)});
    @(posedge clk);
    m_step(we, a, wd, ev, tr);
    @(negedge clk);
  endtask

  task automatic idle(int n, bit [NEV-1:0] ev, bit tr);
    for (int k = 0; k < n; k++) cyc(0, 2'(k), 0, ev, tr);
  endtask

  function automatic bit [31:0] ctrl_word(bit en, bit psc, bit [2:0] ien,
                                          bit [7:0] s0, bit [7:0] s1);
    return {4'b0, s0, s1, 4'b0, 1'b0, ien, psc, 2'b0, en};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; ev_pulse = 0; trace_in = 0;
    m_en = 0; m_psc = 0; m_ien = 0; m_ovf = 0; m_sel0 = 0; m_sel1 = 0;
    m_c0 = 0; m_c1 = 0; m_cy = 0; m_pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; idle(8, 0, 0);

    req = "R3";
    cyc(1, 0, ctrl_word(0, 0, 3'b111, 8'd3, 8'h20) | 32'hF000_0880, 0, 0);
    idle(4, 0, 0);
    req = "R2";
    cyc(1, 2, 32'h1234_5678, 0, 0);
    cyc(1, 3, 32'h0000_0010, 0, 0);
    cyc(1, 1, 32'h0000_0100, 0, 0);
    idle(4, 0, 0);
    cyc(1, 3, 32'h0, 0, 0);
    idle(4, 0, 0);

    req = "R6";
    idle(8, 32'hFFFF_FFFF, 1);

    req = "R4";
    cyc(1, 0, ctrl_word(1, 0, 3'b111, 8'd3, 8'h20), 0, 0);
    for (int k = 0; k < 24; k++) cyc(0, 2'(k), 0, (k % 3 == 0) ? 32'h8 : 32'h7, k[1]);
    req = "R5";
    for (int k = 0; k < 12; k++) cyc(0, 2'(k), 0, 32'h8, k < 5);
    idle(6, 32'h8, 0);
    req = "R4";
    cyc(1, 0, ctrl_word(1, 0, 3'b111, 8'h40, 8'd31), 0, 0);
    idle(8, 32'hFFFF_FFFF, 0);

    req = "R8";
    cyc(1, 0, ctrl_word(1, 0, 3'b111, 8'd5, 8'd6) | 32'h2, 32'h60, 0);
    idle(4, 32'h20, 0);
    cyc(1, 0, ctrl_word(1, 0, 3'b111, 8'd5, 8'd6) | 32'h4, 0, 0);
    idle(4, 0, 0);

    req = "R9";
    cyc(1, 0, ctrl_word(1, 0, 3'b010, 8'd5, 8'h20), 0, 0);
    cyc(1, 3, 32'hFFFF_FFFD, 0, 0);
    idle(8, 0, 1);
    req = "R10";
    cyc(1, 0, ctrl_word(1, 0, 3'b010, 8'd5, 8'h20), 0, 0);
    idle(4, 0, 0);
    cyc(1, 0, ctrl_word(1, 0, 3'b010, 8'd5, 8'h20) | 32'h200, 0, 0);
    idle(4, 0, 0);
    cyc(1, 2, 32'hFFFF_FFFF, 0, 0);
    cyc(1, 0, ctrl_word(1, 0, 3'b011, 8'd5, 8'h20) | 32'h100, 32'h20, 0);
    idle(4, 0, 0);

    req = "R12";
    cyc(1, 2, 32'hABCD_0000, 32'h20, 0);
    cyc(1, 0, ctrl_word(1, 0, 3'b011, 8'd5, 8'h20) | 32'h702, 32'h20, 1);
    idle(4, 32'h20, 0);

    req = "R7";
    cyc(1, 0, ctrl_word(1, 1, 3'b100, 8'd5, 8'h20) | 32'h4, 0, 0);
    idle(200, 0, 0);
    cyc(1, 0, ctrl_word(1, 1, 3'b100, 8'd5, 8'h20) | 32'h4, 0, 0);
    idle(70, 0, 0);
    cyc(1, 1, 32'hFFFF_FFF0, 0, 0);
    cyc(1, 0, ctrl_word(1, 0, 3'b100, 8'd5, 8'h20), 0, 0);
    idle(24, 0, 0);

    req = "R4";
    lfsr = 32'hACE1_2345;
    cyc(1, 0, ctrl_word(1, 0, 3'b111, 8'd9, 8'd30) | 32'h700, 0, 0);
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 500 == 499)
        cyc(1, 0, ctrl_word(lfsr[3], lfsr[4], lfsr[7:5], lfsr[15:8], lfsr[23:16]) | {21'b0, lfsr[10:8], 8'b0}, lfsr, lfsr[9]);
      else if (k % 700 == 350)
        cyc(1, 2'(k), 32'hFFFF_FF00 | lfsr[7:0], lfsr, lfsr[9]);
      else
        cyc(0, 2'(k), 0, lfsr, lfsr[9]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule